// File: doc/BRIEF.md
# Keyed Configuration Gate for a Super I/O Port Pair

This block sits on an I/O-port bus as a slave and protects the configuration space of a super I/O controller. Software writes an index byte to a configuration port and a value to a neighbouring data port. A data-port write only reaches the configuration space when the part has first been unlocked. Unlocking takes a two-byte key written to the configuration port. A second two-byte key locks it again. A four-state sequencer watches every configuration-port write and decides whether the gate is open. Each missed key byte sends it back to a defined state.

An accepted data-port write leaves the block on a valid/ready output channel. The channel carries the index, which is the last byte written to the configuration port, and the data byte. The slot holds one entry. `cfg_valid` stays high, with `cfg_index` and `cfg_data` unchanged, until a cycle in which `cfg_ready` is high. An accepted write that arrives while the slot is full and not being drained is dropped. A write that arrives in the same cycle the slot drains replaces the entry. The `sio_decode_en` input decides whether the two ports respond at all. Two delay ports are always claimed on writes, and writes to them have no effect.

Top module: `sio_cfg_gate`

## Requirements
- R1: After reset the key state is locked-idle, the last configuration byte reads 0x00, `cfg_active` is low and `cfg_valid` is low.
- R2: In the idle state, a configuration-port write of 0x80 arms the sequencer. Any other byte leaves it idle.
- R3: In the armed state, 0x86 opens the gate. 0x80 keeps it armed. Any other byte returns it to idle.
- R4: In the open state, 0x68 moves to the closing state. Any other byte keeps it open.
- R5: In the closing state, 0x08 returns to idle and locks the gate. 0x68 stays in the closing state. Any other byte returns to the open state.
- R6: `cfg_active` is high exactly in the open and closing states. It changes on the same clock edge that registers the keying write.
- R7: A data-port write in idle or armed is discarded. In open or closing it is presented on the output with the last configuration byte as `cfg_index` and the written byte as `cfg_data`. `cfg_valid` rises on the edge that registers the write.
- R8: A read of the configuration port returns the last byte written to it. A read of the data port returns 0xFF. Reads never change the key state.
- R9: While `sio_decode_en` is low, the configuration and data ports (0x004E and 0x004F) are not claimed, and writes to them change neither the key state nor the stored byte.
- R10: Writes to 0x0080 and 0x00ED are claimed whether or not decode is enabled, and change neither the state nor the output. Reads of these ports are not claimed.
- R11: While `cfg_valid` is high and `cfg_ready` is low, the output stays valid with a stable payload. A newly accepted write is then dropped.
- R12: Only the exact 16-bit port addresses are claimed. Any other address leaves `io_claim` low and `io_rdata` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sio_decode_en | input | 1 | Enables decode of the configuration and data ports |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the cycle of `io_rd` |
| io_claim | output | 1 | The access targets a port of this block |
| cfg_active | output | 1 | Configuration gate open |
| cfg_valid | output | 1 | Accepted configuration write pending |
| cfg_ready | input | 1 | Consumer takes the pending write |
| cfg_index | output | 8 | Index of the pending write |
| cfg_data | output | 8 | Data of the pending write |

## Verification
The sequencer is swept from each of its four states with every one of the 256 byte values. After each step, a follow-up probe byte is written and `cfg_active` is checked. The probe tells the states apart that the active flag alone cannot: 0x86 separates idle from armed, and 0x08 separates open from closing. Data-port writes are tried in every state, so that acceptance, the index taken from the last configuration byte and the dropping in locked states are all observed. Further patterns cover disabled decode, the delay ports, near-miss addresses, and a stalled consumer facing a second accepted write.

// File: rtl/sio_key_pkg.sv
package sio_key_pkg;
  typedef enum logic [1:0] {
    KS_IDLE    = 2'd0,
    KS_ARMED   = 2'd1,
    KS_OPEN    = 2'd2,
    KS_CLOSING = 2'd3
  } key_state_e;

  function automatic logic state_is_open(key_state_e s);
    return (s == KS_OPEN) || (s == KS_CLOSING);
  endfunction
endpackage

// File: rtl/sio_port_decode.sv
module sio_port_decode #(
  parameter int ADDR_W = 16,
  parameter int NUM_DLY = 2,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 16'h004E,
  parameter logic [ADDR_W-1:0] DAT_ADDR = 16'h004F,
  parameter logic [NUM_DLY*ADDR_W-1:0] DLY_ADDRS = {16'h00ED, 16'h0080}
) (
  input  logic              dec_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              hit_cfg,
  output logic              hit_dat,
  output logic              hit_dly,
  output logic              claim
);
  logic [NUM_DLY-1:0] dly_match;

  generate
    for (genvar i = 0; i < NUM_DLY; i++) begin : g_dly
      assign dly_match[i] = (addr == DLY_ADDRS[i*ADDR_W +: ADDR_W]);
    end
  endgenerate

  assign hit_cfg = dec_en && (addr == CFG_ADDR) && (wr || rd);
  assign hit_dat = dec_en && (addr == DAT_ADDR) && (wr || rd);
  assign hit_dly = wr && (|dly_match);
  assign claim   = hit_cfg || hit_dat || hit_dly;
endmodule

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
  import sio_key_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY_ARM   = 8'h80,
  parameter logic [DATA_W-1:0] KEY_OPEN  = 8'h86,
  parameter logic [DATA_W-1:0] KEY_CLOSE = 8'h68,
  parameter logic [DATA_W-1:0] KEY_LOCK  = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wbyte,
  output key_state_e        state,
  output logic [DATA_W-1:0] last_byte,
  output logic              active
);
  key_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      KS_IDLE:    nxt = (wbyte == KEY_ARM) ? KS_ARMED : KS_IDLE;
      KS_ARMED:   nxt = (wbyte == KEY_OPEN) ? KS_OPEN :
                        (wbyte == KEY_ARM)  ? KS_ARMED : KS_IDLE;
      KS_OPEN:    nxt = (wbyte == KEY_CLOSE) ? KS_CLOSING : KS_OPEN;
      KS_CLOSING: nxt = (wbyte == KEY_LOCK)  ? KS_IDLE :
                        (wbyte == KEY_CLOSE) ? KS_CLOSING : KS_OPEN;
      default:    nxt = KS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= KS_IDLE;
      last_byte <= '0;
      active    <= 1'b0;
    end else if (wr_stb) begin
      state     <= nxt;
      last_byte <= wbyte;
      active    <= state_is_open(nxt);
    end
  end

  // R8
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(state) && $stable(last_byte));
  // R3
  open_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(wr_stb && wbyte == KEY_OPEN));
  // R5
  lock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> $past(wr_stb && wbyte == KEY_LOCK));
endmodule

// File: rtl/sio_out_slot.sv
module sio_out_slot #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_idx,
  input  logic [DATA_W-1:0] push_dat,
  input  logic              ready,
  output logic              valid,
  output logic [DATA_W-1:0] idx,
  output logic [DATA_W-1:0] dat
);
  logic room;
  assign room = !valid || ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      idx   <= '0;
      dat   <= '0;
    end else if (push && room) begin
      valid <= 1'b1;
      idx   <= push_idx;
      dat   <= push_dat;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  // R11
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(idx) && $stable(dat));
endmodule

// File: rtl/sio_cfg_gate.sv
module sio_cfg_gate
  import sio_key_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 16'h004E,
  parameter logic [ADDR_W-1:0] DAT_ADDR = 16'h004F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sio_decode_en,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              io_claim,
  output logic              cfg_active,
  output logic              cfg_valid,
  input  logic              cfg_ready,
  output logic [DATA_W-1:0] cfg_index,
  output logic [DATA_W-1:0] cfg_data
);
  localparam logic [DATA_W-1:0] DAT_READ_VAL = '1;

  logic hit_cfg, hit_dat, hit_dly;
  logic cfg_wr, dat_wr, dat_acc;
  key_state_e        state;
  logic [DATA_W-1:0] last_byte;

  sio_port_decode #(
    .ADDR_W(ADDR_W), .NUM_DLY(2),
    .CFG_ADDR(CFG_ADDR), .DAT_ADDR(DAT_ADDR),
    .DLY_ADDRS({16'h00ED, 16'h0080})
  ) u_dec (
    .dec_en(sio_decode_en), .addr(io_addr), .wr(io_wr), .rd(io_rd),
    .hit_cfg(hit_cfg), .hit_dat(hit_dat), .hit_dly(hit_dly), .claim(io_claim)
  );

  assign cfg_wr  = hit_cfg && io_wr;
  assign dat_wr  = hit_dat && io_wr;
  assign dat_acc = dat_wr && state_is_open(state);

  sio_key_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_stb(cfg_wr), .wbyte(io_wdata),
    .state(state), .last_byte(last_byte), .active(cfg_active)
  );

  sio_out_slot #(.DATA_W(DATA_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .push(dat_acc),
    .push_idx(last_byte), .push_dat(io_wdata), .ready(cfg_ready),
    .valid(cfg_valid), .idx(cfg_index), .dat(cfg_data)
  );

  always_comb begin
    io_rdata = '0;
    if (io_rd && hit_cfg)      io_rdata = last_byte;
    else if (io_rd && hit_dat) io_rdata = DAT_READ_VAL;
  end

  // R7
  accept_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_valid) |-> $past(cfg_active));
  // R10
  delay_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_dly && !hit_cfg && !hit_dat) |=> $stable(cfg_active));
endmodule

// File: tb/tb_sio_cfg_gate.sv
module tb_sio_cfg_gate;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic [15:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0, ready = 1'b1;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, idx, dat;
  logic claim, active, valid;

  int n_vec = 0, n_bad = 0;
  int m_state = 0;
  logic [7:0] m_last = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_cfg_gate dut (
    .clk(clk), .rst_n(rst_n), .sio_decode_en(en), .io_addr(addr),
    .io_wr(wr), .io_rd(rd), .io_wdata(wdata), .io_rdata(rdata),
    .io_claim(claim), .cfg_active(active), .cfg_valid(valid),
    .cfg_ready(ready), .cfg_index(idx), .cfg_data(dat)
  );

  function automatic int nxt(int s, logic [7:0] b);
    case (s)
      0: return (b == 8'h80) ? 1 : 0;
      1: return (b == 8'h86) ? 2 : (b == 8'h80) ? 1 : 0;
      2: return (b == 8'h68) ? 3 : 2;
      default: return (b == 8'h08) ? 0 : (b == 8'h68) ? 3 : 2;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; wr = 0; rd = 0; en = 1; ready = 1;
    @(negedge clk); @(negedge clk); rst_n = 1;
    m_state = 0; m_last = 8'h00;
  endtask

  task automatic io_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic cfg_write(logic [7:0] d);
    io_write(16'h004E, d);
    if (en) begin m_state = nxt(m_state, d); m_last = d; end
  endtask

  task automatic io_read(logic [15:0] a, output logic [7:0] d, output logic c);
    @(negedge clk); addr = a; rd = 1; #1; d = rdata; c = claim; rd = 0;
  endtask

  task automatic goto_state(int s);
    do_reset();
    if (s >= 1) cfg_write(8'h80);
    if (s >= 2) cfg_write(8'h86);
    if (s >= 3) cfg_write(8'h68);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] r; logic c;
    do_reset();
    // R1 reset state
    chk("R1 active", active, 0);
    chk("R1 valid", valid, 0);
    io_read(16'h004E, r, c);
    chk("R1 last byte", r, 8'h00);

    // R2 R3 R4 R5 R6 sweep: every byte from every state, then a probe
    for (int s = 0; s < 4; s++) begin
      for (int b = 0; b < 256; b++) begin
        goto_state(s);
        cfg_write(8'(b));
        chk("R6 active after key byte", active, (m_state >= 2) ? 1 : 0);
        cfg_write((m_state < 2) ? 8'h86 : 8'h08);
        case (s)
          0: chk("R2 probe", active, (m_state >= 2) ? 1 : 0);
          1: chk("R3 probe", active, (m_state >= 2) ? 1 : 0);
          2: chk("R4 probe", active, (m_state >= 2) ? 1 : 0);
          default: chk("R5 probe", active, (m_state >= 2) ? 1 : 0);
        endcase
      end
    end

    // R7 data writes per state
    for (int s = 0; s < 4; s++) begin
      goto_state(s);
      io_write(16'h004F, 8'hA0 + 8'(s));
      chk("R7 valid", valid, (s >= 2) ? 1 : 0);
      if (s >= 2) begin
        chk("R7 index", idx, m_last);
        chk("R7 data", dat, 8'hA0 + s);
      end
      @(negedge clk);
      chk("R7 drained", valid, 0);
    end

    // R8 reads
    goto_state(2);
    cfg_write(8'h3C);
    for (int k = 0; k < 3; k++) begin
      io_read(16'h004E, r, c);
      chk("R8 cfg read", r, 8'h3C);
      io_read(16'h004F, r, c);
      chk("R8 data read", r, 8'hFF);
    end
    chk("R8 state after reads", active, 1);

    // R9 decode disabled
    en = 0;
    io_read(16'h004E, r, c);
    chk("R9 unclaimed", c, 0);
    io_write(16'h004E, 8'h68);
    io_write(16'h004E, 8'h08);
    io_write(16'h004F, 8'h11);
    chk("R9 no output", valid, 0);
    en = 1;
    chk("R9 still active", active, 1);
    io_read(16'h004E, r, c);
    chk("R9 byte kept", r, 8'h3C);

    // R10 delay ports
    for (int e = 0; e < 2; e++) begin
      en = 1'(e);
      @(negedge clk); addr = 16'h0080; wr = 1; #1; chk("R10 claim 80", claim, 1);
      @(negedge clk); wr = 0;
      @(negedge clk); addr = 16'h00ED; wr = 1; #1; chk("R10 claim ED", claim, 1);
      @(negedge clk); wr = 0;
      chk("R10 no output", valid, 0);
      chk("R10 active kept", active, 1);
    end
    en = 1;
    io_read(16'h0080, r, c);
    chk("R10 read unclaimed", c, 0);

    // R12 near-miss addresses
    io_read(16'h014E, r, c); chk("R12 claim", c, 0); chk("R12 rdata", r, 0);
    io_read(16'h004D, r, c); chk("R12 claim low", c, 0);
    io_read(16'h00EC, r, c); chk("R12 claim EC", c, 0);

    // R11 back-pressure
    ready = 0;
    io_write(16'h004F, 8'h55);
    io_write(16'h004F, 8'h66);
    @(negedge clk);
    chk("R11 held", valid, 1);
    chk("R11 data kept", dat, 8'h55);
    chk("R11 index kept", idx, 8'h3C);
    ready = 1;
    @(negedge clk);
    chk("R11 released", valid, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule